// File: doc/BRIEF.md
# Flash Erase Sequencer

This block runs a chip-wide or single-sector erase on a parallel NOR flash from the host side. When it accepts a one-cycle `start` request, it stores the erase type and the sector address. It then drives six command writes over a simple synchronous bus master port and polls the flash status word until the erase ends. The block reports the outcome on a one-cycle `done` or `error` pulse. `busy` covers the whole operation.

The status word is checked in a fixed order on every poll:

1. If the completion bit (bit 7) reads 1, the erase has succeeded.
2. Otherwise, if the toggle bit (bit 6) has the same value on two consecutive reads, the erase has also succeeded.
3. Otherwise, if the time-limit bit (bit 5) is set, the block makes one more read. This guards against the flash finishing in the same moment.
4. If that extra read still shows the erase in progress, the block writes the read-mode return command (F0h) and then signals an error.

A host-side watchdog gives the same abort path if the erase neither finishes nor raises bit 5.

The controller is a Moore state machine with these states:

| State | Action | Next state |
|---|---|---|
| `ST_IDLE` | Waits for a request | `ST_CMD` on `start` |
| `ST_CMD` | Drives the write for the current step, six steps in all | `ST_POLL_RD` after the sixth write |
| `ST_POLL_RD` | Issues a status read | `ST_POLL_EVAL` |
| `ST_POLL_EVAL` | Evaluates the returned word | `ST_DONE` on completion, `ST_RECHK_RD` on bit 5, `ST_ABORT_WR` when the watchdog has expired, otherwise `ST_POLL_RD` |
| `ST_RECHK_RD` | Issues the confirming read | `ST_RECHK_EVAL` |
| `ST_RECHK_EVAL` | Evaluates the confirming word | `ST_DONE` on completion, otherwise `ST_ABORT_WR` |
| `ST_ABORT_WR` | Writes F0h at address 0 | `ST_FAIL` |
| `ST_DONE` | Pulses `done` | `ST_IDLE` |
| `ST_FAIL` | Pulses `error` | `ST_IDLE` |

Top module: `flash_erase_seq`

## Requirements
- R1: A chip erase (`chip_mode`=1) drives exactly six writes as (address, data): (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, 80h), (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, 10h). UNLOCK_A defaults to 555h and UNLOCK_B to 2AAh. The writes go out on consecutive cycles, and the first one is in the cycle after `start` is accepted.
- R2: A sector erase (`chip_mode`=0) drives the same first five writes. Its sixth write is 30h at the sector address captured with `start`.
- R3: `bus_rdata` is taken one cycle after `bus_rd`. A status word with bit 7 = 1 ends the erase with a `done` pulse and no F0h write.
- R4: The erase also ends with `done` when bit 6 has the same value on two consecutive status reads, even though bit 7 stays 0.
- R5: A read with bit 5 = 1 (and no completion) causes exactly one more read. If that read shows completion by bit 7 or by a stable bit 6, the result is `done`.
- R6: If that extra read still shows bit 6 toggling, the block writes F0h at address 0. The `error` pulse follows in the next cycle.
- R7: If polling lasts WDOG_CYCLES cycles without completion or bit 5, the block writes F0h and then pulses `error`.
- R8: `busy` is high from the cycle after `start` is accepted through the result pulse, and low in the cycle after it. A `start` that arrives while `busy` is high is ignored: no extra writes, and no change of erase type.
- R9: `done` and `error` are one-cycle pulses and are never high together.
- R10: During and right after reset, `busy`, `done`, `error`, `bus_wr` and `bus_rd` are all low.
- R11: `bus_wr` and `bus_rd` are never high together, and both stay low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Erase request, taken only while idle |
| chip_mode | input | 1 | 1 = whole chip, 0 = one sector |
| sector_addr | input | ADDR_W | Address of the sector to erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Read data, valid the cycle after `bus_rd` |

## Verification
The flash model returns five kinds of status stream:

- **Completion bit rises after some toggling reads.** This exercises only the bit-7 path.
- **Toggle bit freezes while bit 7 stays low.** This separates the toggle comparison from the bit-7 check.
- **Bit 5 is set and toggling continues.** This must end in F0h and `error`.
- **Bit 5 is set and the very next read is stable.** This race case must end in `done`, and shows that the confirming read is made.
- **Toggling never stops.** Only the watchdog can end this case.

Each outcome is run with both erase types. For every run the bench checks all six command writes and whether F0h was written. It also checks that a `start` issued while busy changes nothing.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL_RD,
        ST_POLL_EVAL,
        ST_RECHK_RD,
        ST_RECHK_EVAL,
        ST_ABORT_WR,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam int STEP_W    = 3;
    localparam int CMD_STEPS = 6;

    localparam logic [7:0] CMD_UNLOCK_1   = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_2   = 8'h55;
    localparam logic [7:0] CMD_SETUP      = 8'h80;
    localparam logic [7:0] CMD_CHIP       = 8'h10;
    localparam logic [7:0] CMD_SECTOR     = 8'h30;
    localparam logic [7:0] CMD_READ_RESET = 8'hF0;

    localparam int BIT_POLL   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;

endpackage

// File: rtl/erase_cmd_rom.sv
module erase_cmd_rom
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 'h555,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 'h2AA
) (
    input  logic [STEP_W-1:0] step,
    input  logic              chip_mode,
    input  logic [ADDR_W-1:0] sector_addr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    // Step-indexed command table; the last entry depends on erase type.
    always_comb begin
        unique case (step)
            3'd0: begin cmd_addr = UNLOCK_A; cmd_data = DATA_W'(CMD_UNLOCK_1); end
            3'd1: begin cmd_addr = UNLOCK_B; cmd_data = DATA_W'(CMD_UNLOCK_2); end
            3'd2: begin cmd_addr = UNLOCK_A; cmd_data = DATA_W'(CMD_SETUP);    end
            3'd3: begin cmd_addr = UNLOCK_A; cmd_data = DATA_W'(CMD_UNLOCK_1); end
            3'd4: begin cmd_addr = UNLOCK_B; cmd_data = DATA_W'(CMD_UNLOCK_2); end
            default: begin
                if (chip_mode) begin
                    cmd_addr = UNLOCK_A;
                    cmd_data = DATA_W'(CMD_CHIP);
                end else begin
                    cmd_addr = sector_addr;
                    cmd_data = DATA_W'(CMD_SECTOR);
                end
            end
        endcase
    end

endmodule

// File: rtl/erase_status_eval.sv
module erase_status_eval
    import erase_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic              prev_toggle,
    input  logic              have_prev,
    output logic              complete,
    output logic              limit_hit,
    output logic              cur_toggle
);

    localparam logic [DATA_W-1:0] USED_MASK = DATA_W'(8'hE0);

    logic unused_bits;
    assign unused_bits = ^(rdata & ~USED_MASK);

    always_comb begin
        cur_toggle = rdata[BIT_TOGGLE];
        complete   = rdata[BIT_POLL] | (have_prev & (rdata[BIT_TOGGLE] == prev_toggle));
        limit_hit  = rdata[BIT_LIMIT];
    end

endmodule

// File: rtl/erase_watchdog.sv
module erase_watchdog #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CW'(LIMIT));

    AST_WDOG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired); // R7

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter logic [ADDR_W-1:0] UNLOCK_A = 'h555,
    parameter logic [ADDR_W-1:0] UNLOCK_B = 'h2AA,
    parameter int WDOG_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chip_mode,
    input  logic [ADDR_W-1:0] sector_addr,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CMD_STEPS - 1);

    seq_state_t        state, state_nx;
    logic [STEP_W-1:0] step;
    logic              chip_q;
    logic [ADDR_W-1:0] sector_q;
    logic              prev_toggle;
    logic              have_prev;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              complete, limit_hit, cur_toggle;
    logic              wd_run, wd_expired;

    erase_cmd_rom #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .UNLOCK_A (UNLOCK_A),
        .UNLOCK_B (UNLOCK_B)
    ) u_rom (
        .step        (step),
        .chip_mode   (chip_q),
        .sector_addr (sector_q),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data)
    );

    erase_status_eval #(.DATA_W(DATA_W)) u_eval (
        .rdata       (bus_rdata),
        .prev_toggle (prev_toggle),
        .have_prev   (have_prev),
        .complete    (complete),
        .limit_hit   (limit_hit),
        .cur_toggle  (cur_toggle)
    );

    assign wd_run = (state == ST_POLL_RD)  || (state == ST_POLL_EVAL) ||
                    (state == ST_RECHK_RD) || (state == ST_RECHK_EVAL);

    erase_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_run),
        .expired (wd_expired)
    );

    // State register and captured request / poll history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            step        <= '0;
            chip_q      <= 1'b0;
            sector_q    <= '0;
            prev_toggle <= 1'b0;
            have_prev   <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        chip_q   <= chip_mode;
                        sector_q <= sector_addr;
                        step     <= '0;
                    end
                end
                ST_CMD: begin
                    step      <= step + 1'b1;
                    have_prev <= 1'b0;
                end
                ST_POLL_EVAL, ST_RECHK_EVAL: begin
                    prev_toggle <= cur_toggle;
                    have_prev   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start) state_nx = ST_CMD;
            ST_CMD:        if (step == LAST_STEP) state_nx = ST_POLL_RD;
            ST_POLL_RD:    state_nx = ST_POLL_EVAL;
            ST_POLL_EVAL: begin
                if (complete)        state_nx = ST_DONE;
                else if (limit_hit)  state_nx = ST_RECHK_RD;
                else if (wd_expired) state_nx = ST_ABORT_WR;
                else                 state_nx = ST_POLL_RD;
            end
            ST_RECHK_RD:   state_nx = ST_RECHK_EVAL;
            ST_RECHK_EVAL: state_nx = complete ? ST_DONE : ST_ABORT_WR;
            ST_ABORT_WR:   state_nx = ST_FAIL;
            ST_DONE:       state_nx = ST_IDLE;
            ST_FAIL:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        error     = (state == ST_FAIL);
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_CMD: begin
                bus_wr    = 1'b1;
                bus_addr  = cmd_addr;
                bus_wdata = cmd_data;
            end
            ST_ABORT_WR: begin
                bus_wr    = 1'b1;
                bus_wdata = DATA_W'(CMD_READ_RESET);
            end
            ST_POLL_RD, ST_RECHK_RD: bus_rd = 1'b1;
            default: ;
        endcase
    end

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_wr && !bus_rd)); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R9
    AST_ERR_AFTER_F0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> ($past(bus_wr) && $past(bus_wdata) == DATA_W'(CMD_READ_RESET))); // R6
    AST_FREE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !busy); // R8

endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int WDOG   = 64;
    localparam logic [ADDR_W-1:0] UA = 20'h00555;
    localparam logic [ADDR_W-1:0] UB = 20'h002AA;

    // Scenario codes of the flash status model
    localparam int SC_POLL7  = 0;
    localparam int SC_TOGGLE = 1;
    localparam int SC_FAIL   = 2;
    localparam int SC_RACE   = 3;
    localparam int SC_HANG   = 4;

    // Vector fields: [11] chip, [10:8] scenario, [7] expect error, [6] poke start, [5:0] toggling reads
    localparam int NVEC = 8;
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 1'b0, 1'b0, 6'd3},
        {1'b0, 3'd0, 1'b0, 1'b0, 6'd5},
        {1'b1, 3'd1, 1'b0, 1'b0, 6'd4},
        {1'b0, 3'd1, 1'b0, 1'b0, 6'd0},
        {1'b0, 3'd2, 1'b1, 1'b0, 6'd2},
        {1'b1, 3'd3, 1'b0, 1'b0, 6'd3},
        {1'b0, 3'd4, 1'b1, 1'b0, 6'd0},
        {1'b1, 3'd0, 1'b0, 1'b1, 6'd6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              chip_mode = 1'b0;
    logic [ADDR_W-1:0] sector_addr = '0;
    logic              busy, done, error, bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    flash_erase_seq #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .UNLOCK_A    (UA),
        .UNLOCK_B    (UB),
        .WDOG_CYCLES (WDOG)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .chip_mode   (chip_mode),
        .sector_addr (sector_addr),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata)
    );

    // Flash status model
    logic              m_clr = 1'b0;
    int                m_sc  = 0;
    int                m_n   = 0;
    int                wr_cnt, rd_cnt;
    logic              f0_seen, last6;
    logic [ADDR_W-1:0] wa [16];
    logic [DATA_W-1:0] wd [16];
    logic              toggling, flag5;
    logic [DATA_W-1:0] model_val;

    always_comb begin
        toggling = (rd_cnt < m_n) || (m_sc == SC_FAIL) || (m_sc == SC_HANG) ||
                   (m_sc == SC_RACE && rd_cnt == m_n);
        flag5    = (m_sc == SC_FAIL && rd_cnt >= m_n) || (m_sc == SC_RACE && rd_cnt == m_n);
        if (toggling)            model_val = {9'd0, ~last6, flag5, 5'd0};
        else if (m_sc == SC_POLL7) model_val = 16'hFFFF;
        else                     model_val = {9'd0, last6, 6'd0};
    end

    always @(posedge clk) begin
        if (m_clr) begin
            wr_cnt  <= 0;
            rd_cnt  <= 0;
            f0_seen <= 1'b0;
            last6   <= 1'b0;
        end else begin
            if (bus_wr) begin
                wa[wr_cnt[3:0]] <= bus_addr;
                wd[wr_cnt[3:0]] <= bus_wdata;
                wr_cnt <= wr_cnt + 1;
                if (bus_wdata == 16'h00F0) f0_seen <= 1'b1;
            end
            if (bus_rd) begin
                rd_cnt    <= rd_cnt + 1;
                bus_rdata <= model_val;
                if (toggling) last6 <= ~last6;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic chip, input int sc, input logic exp_err,
                           input logic poke, input int nrd, input logic [ADDR_W-1:0] sect);
        int cyc;
        logic got_done, got_err;
        @(negedge clk);
        m_sc = sc; m_n = nrd; m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0; chip_mode = chip; sector_addr = sect; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", busy, 1);
        chk("R1 first write in cycle after start", {bus_wr, bus_addr}, {1'b1, UA});
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; chip_mode = ~chip; sector_addr = '0;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!(done || error) && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        got_done = done; got_err = error;
        chk("R9 one outcome done", got_done, !exp_err);
        chk(exp_err ? "R6/R7 error reported" : "R3/R4/R5 error absent", got_err, exp_err);
        @(negedge clk);
        chk("R9 pulse ended, R8 busy low", {done, error, busy}, 3'b000);
        chk(poke ? "R8 restart ignored write count" : "R1/R2 write count",
            wr_cnt, exp_err ? 7 : 6);
        chk("R1 w0", {wa[0], wd[0]}, {UA, 16'h00AA});
        chk("R1 w1", {wa[1], wd[1]}, {UB, 16'h0055});
        chk("R1 w2", {wa[2], wd[2]}, {UA, 16'h0080});
        chk("R1 w3", {wa[3], wd[3]}, {UA, 16'h00AA});
        chk("R1 w4", {wa[4], wd[4]}, {UB, 16'h0055});
        if (chip) chk("R1 chip last write", {wa[5], wd[5]}, {UA, 16'h0010});
        else      chk("R2 sector last write", {wa[5], wd[5]}, {sect, 16'h0030});
        chk(exp_err ? "R6/R7 F0 written" : "R3 no F0", f0_seen, exp_err);
        if (exp_err) chk("R6 F0 at address 0", {wa[6], wd[6]}, {20'h0, 16'h00F0});
        if (sc == SC_RACE) chk("R5 exactly one extra read", rd_cnt, nrd + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_clr = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 outputs in reset", {busy, done, error, bus_wr, bus_rd}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 outputs after reset", {busy, done, error, bus_wr, bus_rd}, 5'b0);
        m_clr = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i][11], int'(VEC[i][10:8]), VEC[i][7], VEC[i][6],
                    int'(VEC[i][5:0]), 20'h3A000 + ADDR_W'(i) * 20'h01000);
        end

        // Directed: watchdog with chip erase (R7)
        run_vec(1'b1, SC_HANG, 1'b1, 1'b0, 0, '0);
        // Directed: race on sector erase with a long prefix (R5)
        run_vec(1'b0, SC_RACE, 1'b0, 1'b0, 7, 20'hFF000);

        // Directed: idle strobes quiet (R11)
        repeat (4) @(negedge clk);
        chk("R11 idle strobes low", {busy, bus_wr, bus_rd}, 3'b000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule